// File: doc/BRIEF.md
# Debug trace buffer recorder

The recorder keeps a 64-entry on-chip history of processor trace words for a debug host. Each cycle the trace source may present one word. The word is written into the buffer when recording is active, when the configured mode accepts it and when the core is not being held. A 3-bit start/stop select decides when recording is active. It can be off, always on, or gated by two of three breakpoint-match pulses, where one pulse arms the recorder and another disarms it.

A 2-bit mode selects between two choices. The first is whether a full buffer silently wraps or raises a core-halt request. The second is whether every word is kept or only the PC-synchronization words, in the profile variant. A debug "go" command rewinds the write pointer, clears the full and halt state and lets the core run again. A separate read port returns stored entries oldest-first, one per request.

Top module: `trace_recorder`

## Requirements
- R1: After reset `halt_o`=0, `full_o`=0 and `rd_data_o`=0.
- R2: With `ss_sel_i`=000 no trace word is written, so the write position does not move.
- R3: With `ss_sel_i`=001 and `mode_i[1]`=0, every cycle with `tr_valid_i`=1 writes `tr_data_i` to the next entry. Entries are kept in arrival order.
- R4: For `ss_sel_i` 010..111 the start source is bit (`ss_sel_i`-2) mod 3 of `bkpt_hit_i` and the stop source is the next bit in the order 0→1→2→0. A start pulse arms recording from the following cycle, and a stop pulse disarms it from the following cycle. When both pulses arrive together, the start pulse wins. When `ss_sel_i` is below 010 the armed state is cleared.
- R5: In non-intrusive modes (`mode_i[0]`=0), `full_o` rises one cycle after the 64th write and stays set until go. Later writes overwrite the oldest entry, and `halt_o` stays 0.
- R6: In intrusive modes (`mode_i[0]`=1), `halt_o` rises one cycle after the write that fills the 64th entry. While `halt_o`=1 no word is written.
- R7: `go_i` clears `halt_o`, `full_o`, the write position and the read offset at the next edge. A word offered in the same cycle as `go_i` is dropped.
- R8: In profile modes (`mode_i[1]`=1), a word is written only if `pc_sync_en_i`=1 and `tr_is_sync_i`=1.
- R9: Each `rd_req_i` returns on `rd_data_o`, one cycle later, the entry at a read offset measured from the oldest entry. The oldest entry is entry 0 before a wrap, or the current write position after a wrap. The offset then advances modulo 64. Reading does not affect recording.
- R10: Reset clears the armed state, so a gated select records nothing until a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bit0 intrusive (halt at full), bit1 PC-profile |
| ss_sel_i | input | 3 | Start/stop select |
| pc_sync_en_i | input | 1 | Periodic PC synchronization enabled |
| tr_valid_i | input | 1 | Trace word present |
| tr_data_i | input | DATA_W | Trace word |
| tr_is_sync_i | input | 1 | Trace word is a PC-sync word |
| bkpt_hit_i | input | 3 | Breakpoint match pulses: 0 address, 1 masked PC, 2 second PC |
| go_i | input | 1 | Debug go command |
| rd_req_i | input | 1 | Read one buffer entry |
| rd_data_o | output | DATA_W | Read data, valid the cycle after a request |
| halt_o | output | 1 | Core halt request |
| full_o | output | 1 | Buffer has filled at least once |

## Verification
Every result of this block appears one clock edge after its cause. `full_o` and `halt_o` follow the edge that stores the 64th word, `rd_data_o` follows the edge that sees `rd_req_i`, and a start or stop pulse changes which words are kept from the next cycle onward. The bench changes inputs on the falling edge and advances its reference model on the rising edge using those inputs. It compares outputs at the following falling edge, so each comparison falls exactly one register stage after its stimulus. Read data is compared only for entries the model knows were written.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam logic [2:0] SEL_OFF    = 3'b000;
  localparam logic [2:0] SEL_ALWAYS = 3'b001;

  // start source for gated selects: (sel-2) mod 3
  function automatic logic [1:0] start_src(input logic [2:0] sel);
    case (sel)
      3'b010, 3'b101: start_src = 2'd0;
      3'b011, 3'b110: start_src = 2'd1;
      default:        start_src = 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] stop_src(input logic [1:0] start);
    stop_src = (start == 2'd2) ? 2'd0 : start + 2'd1;
  endfunction
endpackage

// File: rtl/trc_trigger.sv
module trc_trigger
  import trc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic [2:0] hit_i,
  output logic       active_o
);
  logic [1:0] s_idx, p_idx;
  logic       gated, armed_q;

  assign s_idx = start_src(sel_i);
  assign p_idx = stop_src(s_idx);
  assign gated = (sel_i > SEL_ALWAYS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            armed_q <= 1'b0;
    else if (!gated)        armed_q <= 1'b0;
    else if (hit_i[s_idx])  armed_q <= 1'b1;
    else if (hit_i[p_idx])  armed_q <= 1'b0;
  end

  assign active_o = (sel_i == SEL_ALWAYS) || (gated && armed_q);

  p_start_arms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated && hit_i[s_idx]) |=> armed_q);
  p_stop_disarms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated && hit_i[p_idx] && !hit_i[s_idx]) |=> !armed_q);
endmodule

// File: rtl/trc_wr_ctrl.sv
module trc_wr_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          intrusive_i,
  input  logic          go_i,
  output logic          we_o,
  output logic [AW-1:0] wptr_o,
  output logic          wrap_o,
  output logic          halt_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q;
  logic          wrap_q, halt_q;

  assign we_o = wr_req_i && !halt_q && !go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      wrap_q <= 1'b0;
      halt_q <= 1'b0;
    end else if (go_i) begin
      wptr_q <= '0;
      wrap_q <= 1'b0;
      halt_q <= 1'b0;
    end else if (we_o) begin
      wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (wptr_q == LAST) begin
        wrap_q <= 1'b1;
        if (intrusive_i) halt_q <= 1'b1;
      end
    end
  end

  assign wptr_o = wptr_q;
  assign wrap_o = wrap_q;
  assign halt_o = halt_q;

  p_halt_at_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_q) |-> (wrap_q && wptr_q == '0));
  p_frozen_halted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !go_i) |=> $stable(wptr_q));
  p_go_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (!halt_q && !wrap_q && wptr_q == '0));
  p_full_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_q && !go_i) |=> wrap_q);
endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     wptr_i,
  input  logic              wrap_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_req_i,
  input  logic              go_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_off_q, raddr;
  logic [DATA_W-1:0] rd_q;

  // offset counts from the oldest entry; DEPTH is a power of two
  assign raddr = (wrap_i ? wptr_i : '0) + rd_off_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wptr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_off_q <= '0;
      rd_q     <= '0;
    end else begin
      if (rd_req_i) rd_q <= mem_q[raddr];
      if (go_i)          rd_off_q <= '0;
      else if (rd_req_i) rd_off_q <= rd_off_q + 1'b1;
    end
  end

  assign rd_data_o = rd_q;

  p_rd_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_req_i && !go_i) |=> ($stable(rd_q) && $stable(rd_off_q)));
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [2:0]        ss_sel_i,
  input  logic              pc_sync_en_i,
  input  logic              tr_valid_i,
  input  logic [DATA_W-1:0] tr_data_i,
  input  logic              tr_is_sync_i,
  input  logic [2:0]        bkpt_hit_i,
  input  logic              go_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              halt_o,
  output logic              full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          active, keep, wr_req, we;
  logic [AW-1:0] wptr;
  logic          wrap;

  trc_trigger i_trigger (
    .clk_i, .rst_ni, .sel_i(ss_sel_i), .hit_i(bkpt_hit_i), .active_o(active)
  );

  assign keep   = !mode_i[1] || (pc_sync_en_i && tr_is_sync_i);
  assign wr_req = tr_valid_i && active && keep;

  trc_wr_ctrl #(.DEPTH(DEPTH)) i_wr_ctrl (
    .clk_i, .rst_ni, .wr_req_i(wr_req), .intrusive_i(mode_i[0]), .go_i,
    .we_o(we), .wptr_o(wptr), .wrap_o(wrap), .halt_o(halt_o)
  );

  trc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni, .we_i(we), .wptr_i(wptr), .wrap_i(wrap), .wdata_i(tr_data_i),
    .rd_req_i, .go_i, .rd_data_o
  );

  assign full_o = wrap;

  p_off_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_sel_i == SEL_OFF && !go_i) |=> $stable(wptr));
  p_profile_filter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !(pc_sync_en_i && tr_is_sync_i) && !go_i) |=> $stable(wptr));
  p_quiet_no_halt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[0] && !halt_o) |=> !halt_o);
endmodule

// File: tb/test_trace_recorder.sv
module test_trace_recorder;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  ss_sel_i = '0, bkpt_hit_i = '0;
  logic        pc_sync_en_i = 0, tr_valid_i = 0, tr_is_sync_i = 0, go_i = 0, rd_req_i = 0;
  logic [31:0] tr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        halt_o, full_o;

  always #4 clk_i = ~clk_i;

  trace_recorder i_trace_recorder (.*);

  int total = 0, bad = 0;
  string cur_tag = "R3";

  logic [31:0] m_mem [64];
  bit          m_known [64];
  int          m_wp, m_off;
  bit          m_wrap, m_halt, m_armed, m_rd_chk;
  logic [31:0] m_rd;

  function automatic int f_start(input logic [2:0] s);
    return (int'(s) - 2) % 3;
  endfunction

  function automatic int f_stop(input logic [2:0] s);
    return (f_start(s) + 1) % 3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_wp = 0; m_off = 0; m_wrap = 0; m_halt = 0; m_armed = 0; m_rd = '0; m_rd_chk = 0;
  endtask

  task automatic model_step();
    int idx;
    bit act, keep, acc;
    m_rd_chk = 0;
    if (rd_req_i) begin
      idx = ((m_wrap ? m_wp : 0) + m_off) % 64;
      m_rd = m_mem[idx];
      m_rd_chk = m_known[idx];
      m_off = (m_off + 1) % 64;
    end
    if (go_i) m_off = 0;
    act  = (ss_sel_i == 3'b001) || (ss_sel_i >= 3'b010 && m_armed);
    keep = !mode_i[1] || (pc_sync_en_i && tr_is_sync_i);
    acc  = tr_valid_i && act && keep && !m_halt && !go_i;
    if (go_i) begin
      m_wp = 0; m_wrap = 0; m_halt = 0;
    end else if (acc) begin
      m_mem[m_wp] = tr_data_i;
      m_known[m_wp] = 1;
      if (m_wp == 63) begin
        m_wrap = 1;
        if (mode_i[0]) m_halt = 1;
      end
      m_wp = (m_wp + 1) % 64;
    end
    if (ss_sel_i < 3'b010) m_armed = 0;
    else if (bkpt_hit_i[f_start(ss_sel_i)]) m_armed = 1;
    else if (bkpt_hit_i[f_stop(ss_sel_i)]) m_armed = 0;
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk("R6 halt_o", 32'(halt_o), 32'(m_halt));
    chk("R5 full_o", 32'(full_o), 32'(m_wrap));
    if (m_rd_chk) chk({cur_tag, " R9 rd_data_o"}, rd_data_o, m_rd);
    tr_valid_i = 0; bkpt_hit_i = '0; go_i = 0; rd_req_i = 0;
  endtask

  task automatic word(input logic [31:0] d, input bit sync = 0, input logic [2:0] hit = '0);
    tr_valid_i = 1; tr_data_i = d; tr_is_sync_i = sync; bkpt_hit_i = hit;
    cyc();
  endtask

  task automatic pulse(input logic [2:0] hit);
    bkpt_hit_i = hit;
    cyc();
  endtask

  task automatic rd_burst(input int n);
    for (int i = 0; i < n; i++) begin rd_req_i = 1; cyc(); end
  endtask

  task automatic go();
    go_i = 1; cyc();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    model_reset();
    // R1: reset state
    chk("R1 halt_o", 32'(halt_o), 0);
    chk("R1 full_o", 32'(full_o), 0);
    chk("R1 rd_data_o", rd_data_o, 0);
    rst_ni = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_7a11));
    for (int i = 0; i < 64; i++) begin m_known[i] = 0; m_mem[i] = '0; end
    model_reset();
    do_reset();

    // R3: unconditional recording, oldest-first readout
    cur_tag = "R3"; mode_i = 2'b00; ss_sel_i = 3'b001;
    for (int i = 0; i < 30; i++) begin
      tr_valid_i = ($urandom % 10) < 7; tr_data_i = $urandom; cyc();
    end
    rd_burst(20);

    // R2: select off, then one recorded word must land at the next slot
    cur_tag = "R2"; go();
    for (int i = 0; i < 10; i++) word(32'h1000 + i);
    ss_sel_i = 3'b000;
    for (int i = 0; i < 40; i++) word($urandom, 0, 3'($urandom));
    ss_sel_i = 3'b001; word(32'hA5A5_0001);
    go(); rd_burst(11);

    // R4: gated selects, start/stop sources and start-wins
    cur_tag = "R4";
    for (int s = 2; s < 8; s++) begin
      logic [2:0] st, sp;
      go();
      ss_sel_i = 3'(s);
      st = 3'(1 << f_start(3'(s)));
      sp = 3'(1 << f_stop(3'(s)));
      word(32'hD0 + 32'(s));           // dropped: not armed
      pulse(sp);                        // stop alone: no effect
      word(32'hD1);                     // dropped
      word(32'hB0 + 32'(s), 0, st);     // start same cycle: dropped
      word(32'hB1 + 32'(s));            // kept
      word(32'hB2 + 32'(s), 0, sp);     // stop cycle still kept
      word(32'hD2);                     // dropped
      word(32'hD3, 0, st | sp);         // both: start wins, word dropped
      word(32'hB3 + 32'(s));            // kept
      pulse(3'b111 & ~st & ~sp);        // third source: no effect
      word(32'hB4 + 32'(s));            // kept
      ss_sel_i = 3'b001; go(); rd_burst(4);
    end

    // R10: reset clears the armed state
    cur_tag = "R10"; ss_sel_i = 3'b010; pulse(3'b001); word(32'hC0);
    do_reset();
    word(32'hDEAD_0001); word(32'hDEAD_0002);
    ss_sel_i = 3'b001; word(32'hC1);
    go(); rd_burst(1);

    // R5: non-intrusive wrap overwrites oldest, no halt
    cur_tag = "R5"; go(); mode_i = 2'b00;
    for (int i = 0; i < 63; i++) word(32'h5000 + i);
    chk("R5 not full at 63", 32'(full_o), 0);
    word(32'h5063);
    chk("R5 full after 64", 32'(full_o), 1);
    for (int i = 0; i < 90; i++) word(32'h6000 + i);
    chk("R5 no halt", 32'(halt_o), 0);
    rd_burst(64);

    // R6/R7: intrusive halt at full, go releases
    cur_tag = "R6"; go(); mode_i = 2'b01;
    for (int i = 0; i < 64; i++) word(32'h7000 + i);
    chk("R6 halt after 64", 32'(halt_o), 1);
    for (int i = 0; i < 8; i++) word(32'h7F00 + i);
    rd_burst(66);
    cur_tag = "R7"; go();
    chk("R7 halt cleared", 32'(halt_o), 0);
    chk("R7 full cleared", 32'(full_o), 0);
    word(32'h7777); go(); rd_burst(1);
    go(); word(32'h8888); go_i = 1; tr_valid_i = 1; tr_data_i = 32'h9999; cyc();
    rd_burst(1);

    // R8: profile modes keep only sync words when sync is enabled
    cur_tag = "R8"; go(); mode_i = 2'b10; pc_sync_en_i = 0;
    for (int i = 0; i < 20; i++) word($urandom, 1'($urandom));
    pc_sync_en_i = 1;
    for (int i = 0; i < 40; i++) word($urandom, ($urandom % 3) == 0);
    rd_burst(20);
    go(); mode_i = 2'b11;
    for (int i = 0; i < 220; i++) word($urandom, ($urandom % 2) == 0);
    rd_burst(64);

    // R9: random mix
    cur_tag = "R9"; go();
    for (int i = 0; i < 4000; i++) begin
      if (i % 60 == 0) begin
        mode_i = 2'($urandom); ss_sel_i = 3'($urandom); pc_sync_en_i = 1'($urandom);
      end
      tr_valid_i   = ($urandom % 10) < 6;
      tr_data_i    = $urandom;
      tr_is_sync_i = ($urandom % 10) < 4;
      bkpt_hit_i   = {($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 20) == 0};
      go_i         = ($urandom % 150) == 0;
      rd_req_i     = ($urandom % 10) < 3;
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule